// File: doc/BRIEF.md
# Touch Key Suppression and Output Encoder

This block sits after per-key touch filtering in a capacitive keypad front end. Each cycle it receives a candidate flag and a signal-change magnitude for each of eight keys. It decides which keys may really be reported. When adjacent-key suppression is on, only the key with the strongest signal change in its suppression domain survives. A domain is either all keys or one of two interleaved groups of four.

The surviving key set drives the outputs in one of two forms. In one-per-key form there is one line per key, with selectable polarity and with push-pull or open-drain drive. Open-drain drive is modelled as a per-line output enable. In binary form a three-bit key number is given on the low lines, together with an any-key detect line. The key touched first keeps the code until it is released. The block also decides whether fast detection may be granted to the upstream filters. All configuration is captured while reset is held.

Top module: `touch_key_arbiter`

## Requirements
- R1: `cfg_aks_mode` selects suppression: 2'b00 off, 2'b01 global, 2'b10 two groups, and 2'b11 behaves as off. With suppression off, every used candidate key is active.
- R2: In global mode, a candidate key is active only if no other used candidate has a larger delta, so at most one key is active.
- R3: In group mode, the keys whose index has bit 1 clear (0, 1, 4, 5) form one domain and the other keys (2, 3, 6, 7) form the second. Suppression works only inside a domain, so at most one key per group is active.
- R4: When deltas are equal inside a domain, the key with the lower index wins.
- R5: A key whose `cfg_unused` bit is set is never active and does not suppress any other key.
- R6: `fast_en` is high only when fast detection was requested and suppression is off (mode 00 or 11).
- R7: `detect` is the OR of all active keys. It is active-low only in one-per-key mode with `cfg_active_low` set, and active-high otherwise.
- R8: In one-per-key mode, `key_out[i]` equals active[i] XOR `cfg_active_low`. With push-pull drive `key_oe` is all ones. With open-drain drive `key_oe[i]` is high exactly when `key_out[i]` is 0.
- R9: In binary mode, `key_out[2:0]` holds the reported key number and `key_out[7:3]` are 0. The lines are active-high and `key_oe` is all ones, whatever the polarity and drive settings. With no key active, `key_out` is 0 and `detect` is low.
- R10: In binary mode, the reported key keeps the code while it stays active. Keys that become active later are not shown.
- R11: When the reported key releases while other keys stay active, the lowest-indexed active key is reported next. Keys that become active at the same time as each other are resolved the same way.
- R12: Configuration inputs are sampled only while `rst_n` is low. Changes made after reset have no effect.
- R13: The outputs reflect candidate and delta inputs one clock edge after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cand | input | 8 | Per-key touch candidate flags |
| delta | input | 96 | Per-key signal change, 12 bits per key, key i at bits [12i+11:12i] |
| cfg_aks_mode | input | 2 | Suppression mode (see R1) |
| cfg_binary | input | 1 | 1 selects binary-coded output |
| cfg_active_low | input | 1 | One-per-key polarity |
| cfg_open_drain | input | 1 | One-per-key open-drain drive |
| cfg_unused | input | 8 | Keys excluded from operation |
| cfg_fast_req | input | 1 | Request for fast detection |
| key_out | output | 8 | Output line levels |
| key_oe | output | 8 | Output line drive enables |
| detect | output | 1 | Any-key detect |
| fast_en | output | 1 | Fast detection granted |

## Verification
Suppression results, the binary code and `detect` are all computed from one register stage. They are therefore due exactly one rising edge after the candidates and deltas are presented. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Once, it also samples just before that edge to confirm that the old value is still held. `fast_en` and the polarity and drive choices depend only on the configuration captured in reset. They are checked right after reset is released, and again after the configuration inputs are changed without a reset.

// File: rtl/touch_key_arbiter.sv
module touch_key_arbiter #(
  parameter int N_KEYS  = 8,
  parameter int DELTA_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_KEYS-1:0]         cand,
  input  logic [N_KEYS*DELTA_W-1:0] delta,
  input  logic [1:0]                cfg_aks_mode,
  input  logic                      cfg_binary,
  input  logic                      cfg_active_low,
  input  logic                      cfg_open_drain,
  input  logic [N_KEYS-1:0]         cfg_unused,
  input  logic                      cfg_fast_req,
  output logic [N_KEYS-1:0]         key_out,
  output logic [N_KEYS-1:0]         key_oe,
  output logic                      detect,
  output logic                      fast_en
);
  localparam int CW = $clog2(N_KEYS);
  localparam logic [1:0] SUP_GLOBAL = 2'b01;
  localparam logic [1:0] SUP_GROUP  = 2'b10;

  function automatic logic [N_KEYS-1:0] grp_mask(input logic side);
    logic [N_KEYS-1:0] m;
    for (int k = 0; k < N_KEYS; k++) m[k] = (((k / 2) % 2) == int'(side));
    return m;
  endfunction
  localparam logic [N_KEYS-1:0] GRP_A = grp_mask(1'b0);
  localparam logic [N_KEYS-1:0] GRP_B = grp_mask(1'b1);

  logic [1:0]        aks_q;
  logic              bin_q, low_q, od_q, fastreq_q;
  logic [N_KEYS-1:0] unused_q;
  logic [N_KEYS-1:0] win, active_q;
  logic              rep_valid, nxt_valid;
  logic [CW-1:0]     rep_idx, nxt_idx, lowest;

  always_comb begin
    for (int i = 0; i < N_KEYS; i++) begin
      win[i] = cand[i] & ~unused_q[i];
      for (int j = 0; j < N_KEYS; j++) begin
        if (j != i && cand[j] && !unused_q[j] &&
            (aks_q == SUP_GLOBAL ||
             (aks_q == SUP_GROUP && ((i / 2) % 2) == ((j / 2) % 2)))) begin
          if (delta[j*DELTA_W +: DELTA_W] > delta[i*DELTA_W +: DELTA_W] ||
              (delta[j*DELTA_W +: DELTA_W] == delta[i*DELTA_W +: DELTA_W] && j < i))
            win[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    lowest = '0;
    for (int k = N_KEYS - 1; k >= 0; k--) if (win[k]) lowest = CW'(k);
    nxt_valid = |win;
    if (rep_valid && win[rep_idx]) nxt_idx = rep_idx;
    else                            nxt_idx = nxt_valid ? lowest : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aks_q     <= cfg_aks_mode;
      bin_q     <= cfg_binary;
      low_q     <= cfg_active_low;
      od_q      <= cfg_open_drain;
      unused_q  <= cfg_unused;
      fastreq_q <= cfg_fast_req;
      active_q  <= '0;
      rep_valid <= 1'b0;
      rep_idx   <= '0;
    end else begin
      active_q  <= win;
      rep_valid <= nxt_valid;
      rep_idx   <= nxt_idx;
    end
  end

  logic              inv;
  logic [N_KEYS-1:0] level;
  assign inv     = low_q & ~bin_q;
  assign level   = active_q ^ {N_KEYS{inv}};
  assign key_out = bin_q ? {{(N_KEYS-CW){1'b0}}, rep_idx} : level;
  assign key_oe  = (od_q && !bin_q) ? ~level : '1;
  assign detect  = (|active_q) ^ inv;
  assign fast_en = fastreq_q & (aks_q != SUP_GLOBAL) & (aks_q != SUP_GROUP);

  assert_single_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (aks_q == SUP_GLOBAL) |-> $countones(active_q) <= 1);
  assert_one_per_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (aks_q == SUP_GROUP) |-> ($countones(active_q & GRP_A) <= 1 &&
                              $countones(active_q & GRP_B) <= 1));
  assert_unused_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q & unused_q) == '0);
  assert_fast_only_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en |-> (aks_q != SUP_GLOBAL && aks_q != SUP_GROUP));
  assert_idle_code_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_q && active_q == '0) |-> (key_out == '0 && !detect));
  assert_code_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_q && rep_valid) |=> (!active_q[$past(rep_idx)] || rep_idx == $past(rep_idx)));
endmodule

// File: tb/touch_key_arbiter_bench.sv
module touch_key_arbiter_bench;
  localparam int N = 8;
  localparam int DW = 12;
  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] cand;
  logic [N*DW-1:0] delta;
  logic [1:0] cfg_aks_mode;
  logic cfg_binary, cfg_active_low, cfg_open_drain, cfg_fast_req;
  logic [N-1:0] cfg_unused;
  logic [N-1:0] key_out, key_oe;
  logic detect, fast_en;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  touch_key_arbiter #(.N_KEYS(N), .DELTA_W(DW)) u_touch_key_arbiter (
    .clk(clk), .rst_n(rst_n), .cand(cand), .delta(delta),
    .cfg_aks_mode(cfg_aks_mode), .cfg_binary(cfg_binary),
    .cfg_active_low(cfg_active_low), .cfg_open_drain(cfg_open_drain),
    .cfg_unused(cfg_unused), .cfg_fast_req(cfg_fast_req),
    .key_out(key_out), .key_oe(key_oe), .detect(detect), .fast_en(fast_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic b, input logic lo,
                          input logic od, input logic [N-1:0] un, input logic fr);
    @(negedge clk);
    rst_n = 1'b0; cand = '0; delta = '0;
    cfg_aks_mode = m; cfg_binary = b; cfg_active_low = lo;
    cfg_open_drain = od; cfg_unused = un; cfg_fast_req = fr;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic apply(input logic [N-1:0] c);
    @(negedge clk);
    cand = c;
    @(posedge clk); #1;
  endtask

  task automatic set_d(input int k, input int v);
    delta[k*DW +: DW] = DW'(v);
  endtask

  task automatic t_reset_and_off;
    do_reset(2'b00, 0, 0, 0, '0, 0);
    chk("R13 reset key_out", key_out, 0);
    chk("R7 reset detect", detect, 0);
    chk("R8 reset oe", key_oe, 8'hFF);
    apply(8'hA5);
    chk("R1 off all active", key_out, 8'hA5);
    chk("R7 detect on", detect, 1);
    do_reset(2'b11, 0, 0, 0, '0, 0);
    apply(8'h0F);
    chk("R1 mode 11 as off", key_out, 8'h0F);
  endtask

  task automatic t_latency;
    do_reset(2'b00, 0, 0, 0, '0, 0);
    @(negedge clk);
    cand = 8'h10;
    #2;
    chk("R13 before edge", key_out, 8'h00);
    @(posedge clk); #1;
    chk("R13 after edge", key_out, 8'h10);
  endtask

  task automatic t_global;
    do_reset(2'b01, 0, 0, 0, '0, 0);
    set_d(1, 10); set_d(3, 30); set_d(6, 20);
    apply(8'b0100_1010);
    chk("R2 strongest only", key_out, 8'h08);
    set_d(2, 40); set_d(5, 40);
    apply(8'b0010_0100);
    chk("R4 tie lower index", key_out, 8'h04);
  endtask

  task automatic t_group;
    do_reset(2'b10, 0, 0, 0, '0, 0);
    set_d(0, 5); set_d(1, 9); set_d(2, 3); set_d(7, 8);
    apply(8'b1000_0111);
    chk("R3 one per group", key_out, 8'h82);
    set_d(4, 7); set_d(5, 7);
    apply(8'b0011_0000);
    chk("R4 group tie", key_out, 8'h10);
  endtask

  task automatic t_unused;
    do_reset(2'b01, 0, 0, 0, 8'b0000_1000, 0);
    set_d(3, 99); set_d(4, 10);
    apply(8'b0001_1000);
    chk("R5 unused no suppress", key_out, 8'h10);
    apply(8'b0000_1000);
    chk("R5 unused never active", key_out, 8'h00);
  endtask

  task automatic t_fast;
    do_reset(2'b01, 0, 0, 0, '0, 1);
    chk("R6 global no fast", fast_en, 0);
    do_reset(2'b10, 0, 0, 0, '0, 1);
    chk("R6 group no fast", fast_en, 0);
    do_reset(2'b00, 0, 0, 0, '0, 1);
    chk("R6 off fast", fast_en, 1);
  endtask

  task automatic t_polarity;
    do_reset(2'b00, 0, 1, 0, '0, 0);
    apply(8'h00);
    chk("R7 low idle detect", detect, 1);
    chk("R8 low idle out", key_out, 8'hFF);
    apply(8'h03);
    chk("R8 low pushpull out", key_out, 8'hFC);
    chk("R8 pushpull oe", key_oe, 8'hFF);
    chk("R7 low detect", detect, 0);
    do_reset(2'b00, 0, 1, 1, '0, 0);
    apply(8'h01);
    chk("R8 od low out", key_out, 8'hFE);
    chk("R8 od low oe", key_oe, 8'h01);
    do_reset(2'b00, 0, 0, 1, '0, 0);
    apply(8'h01);
    chk("R8 od high oe", key_oe, 8'hFE);
  endtask

  task automatic t_binary;
    do_reset(2'b00, 1, 1, 1, '0, 0);
    apply(8'h00);
    chk("R9 idle code", key_out, 8'h00);
    chk("R9 idle detect", detect, 0);
    chk("R9 oe", key_oe, 8'hFF);
    apply(8'h20);
    chk("R9 key5 code", key_out, 8'h05);
    chk("R9 detect high", detect, 1);
    apply(8'h24);
    chk("R10 first holds", key_out, 8'h05);
    apply(8'h44);
    chk("R11 lowest latent", key_out, 8'h02);
    apply(8'h40);
    chk("R11 next latent", key_out, 8'h06);
    apply(8'h00);
    chk("R9 release code", key_out, 8'h00);
    apply(8'h90);
    chk("R11 simultaneous", key_out, 8'h04);
  endtask

  task automatic t_cfg_lock;
    do_reset(2'b00, 0, 0, 0, '0, 0);
    @(negedge clk);
    cfg_aks_mode = 2'b01; cfg_binary = 1'b1; cfg_fast_req = 1'b1;
    set_d(1, 50); set_d(3, 10);
    apply(8'h0A);
    chk("R12 mode locked", key_out, 8'h0A);
    chk("R12 fast locked", fast_en, 0);
  endtask

  initial begin
    rst_n = 1'b0; cand = '0; delta = '0;
    cfg_aks_mode = '0; cfg_binary = 0; cfg_active_low = 0;
    cfg_open_drain = 0; cfg_unused = '0; cfg_fast_req = 0;
    t_reset_and_off();
    t_latency();
    t_global();
    t_group();
    t_unused();
    t_fast();
    t_polarity();
    t_binary();
    t_cfg_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule